// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block is the interlock unit of a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory and write-back. The pipeline has no operand forwarding, so the block resolves every hazard by holding stages or by discarding instructions.

Each cycle the block compares the two source registers of the instruction in decode with the destinations of the older instructions in execute and memory. On a read-after-write dependence it freezes the program counter and the fetch/decode register, and it sends a no-op into execute. A branch or jump that resolves as taken in execute squashes the younger instructions. When delay-slot mode is on, only the instruction in fetch is squashed. When instruction and data memory are shared, an access in the memory stage takes the memory port away from fetch for that cycle.

The outputs are combinational and are meant to drive the enables of the pipeline registers directly. The register file is assumed to make a write-back write visible to a read in the same cycle, so a producer in write-back never causes a stall. Write-after-read and write-after-write ordering cannot go wrong in this arrangement, so there is no logic for them.

Top module: `hazard_interlock`

## Requirements
- R1: When decode is valid and a used, nonzero source register equals `ex_rd` while `ex_vld` and `ex_we` are high, the block sets `pc_hold`, `ifid_hold` and `idex_bubble` to 1. With no taken branch and no memory conflict, `if_flush` and `id_flush` stay 0.
- R2: The same stall as R1 is raised when the matching producer is the valid, writing instruction in the memory stage (`mem_rd`, `mem_we`, `mem_vld`).
- R3: A producer whose write enable is low or whose stage is invalid never causes a stall, and an invalid decode instruction never stalls.
- R4: A source field equal to register 0 never causes a dependence, and neither does a source whose use flag is low.
- R5: A taken branch in execute with delay-slot mode off sets `id_flush` and `if_flush` to 1 and drives `pc_hold`, `ifid_hold` and `idex_bubble` to 0, whatever the RAW or memory conditions are.
- R6: A taken branch with delay-slot mode on keeps `id_flush` at 0 and leaves `pc_hold` at 0 so the program counter can redirect. `if_flush` is 1 unless the delay-slot instruction has a RAW stall. In that case `ifid_hold` and `idex_bubble` are 1 and `if_flush` is 0.
- R7: With `shared_mem_en` high, a valid memory-stage access and no taken branch set `pc_hold`. `if_flush` is also set if decode is not stalled. With `shared_mem_en` low the access has no effect on any output.
- R8: `ifid_hold` always equals `idex_bubble`, and `idex_bubble` is never high together with `id_flush`.
- R9: With every stage valid bit low, all five outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used for the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| dslot_en | input | 1 | Delay-slot mode: the instruction after a taken branch completes |
| shared_mem_en | input | 1 | Instruction and data memory share one port |
| id_vld | input | 1 | Decode stage holds a real instruction |
| ex_vld | input | 1 | Execute stage holds a real instruction |
| mem_vld | input | 1 | Memory stage holds a real instruction |
| ex_rd | input | 5 | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes its destination |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes its destination |
| id_rs1 | input | 5 | First source register in decode |
| id_rs1_use | input | 1 | First source is actually read |
| id_rs2 | input | 5 | Second source register in decode |
| id_rs2_use | input | 1 | Second source is actually read |
| ex_br_taken | input | 1 | Branch or jump in execute resolved as taken |
| mem_access | input | 1 | Memory-stage instruction uses the memory port |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode pipeline register |
| idex_bubble | output | 1 | Load a no-op into execute because of a RAW stall |
| if_flush | output | 1 | Fetch/decode register loads a bubble this cycle |
| id_flush | output | 1 | Decode instruction is squashed by a taken branch |

## Verification
A wrong dependence result shows up at the ports in the same cycle as a missing or spurious `pc_hold`/`idex_bubble` pair. In a pipeline that would be a stale operand read, or a lost cycle, in the very next instruction. A wrong squash or priority decision shows up immediately as a mismatch between `id_flush`, `if_flush` and the hold signals. That cycle would let a wrong-path instruction enter execute or drop the delay-slot instruction. The block holds no state, so every error is visible in the same cycle as its cause and cannot hide for several cycles. The checks therefore compare every output pattern directly against the mix of branch, RAW and memory-conflict inputs.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int unsigned HZ_RIDX_W = 5;
  parameter int unsigned HZ_NSRC   = 2;
  parameter int unsigned HZ_NPROD  = 2;

  typedef logic [HZ_RIDX_W-1:0] ridx_t;

  typedef struct packed {
    ridx_t rd;
    logic  we;
    logic  vld;
  } prod_t;

  typedef struct packed {
    ridx_t idx;
    logic  used;
  } src_t;

  // A source waits on a producer when it is read, is not the zero register,
  // and a live writing instruction targets it.
  function automatic logic src_waits(src_t s, prod_t p);
    return s.used && (s.idx != '0) && p.vld && p.we && (p.rd == s.idx);
  endfunction
endpackage

// File: rtl/hz_raw_detect.sv
module hz_raw_detect
  import hz_pkg::*;
#(
  parameter int unsigned NSRC  = HZ_NSRC,
  parameter int unsigned NPROD = HZ_NPROD
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  id_vld,
  input  src_t  src  [NSRC],
  input  prod_t prod [NPROD],
  output logic  raw_stall
);
  logic [NSRC-1:0][NPROD-1:0] dep_hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar p = 0; p < NPROD; p++) begin : g_prod
      assign dep_hit[s][p] = src_waits(src[s], prod[p]);
    end
  end

  assign raw_stall = id_vld && (|dep_hit);

  // R3: an invalid decode slot never requests a stall
  a_r3_idle_decode: assert property (@(posedge clk) disable iff (!rst_n)
    !id_vld |-> !raw_stall);

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    // R4: zero register or unused operand contributes no dependence
    a_r4_quiet_src: assert property (@(posedge clk) disable iff (!rst_n)
      (!src[s].used || src[s].idx == '0) |-> (dep_hit[s] == '0));
  end
endmodule

// File: rtl/hz_squash.sv
module hz_squash (
  input  logic clk,
  input  logic rst_n,
  input  logic ex_vld,
  input  logic ex_br_taken,
  input  logic dslot_en,
  output logic redirect,
  output logic kill_decode
);
  assign redirect    = ex_vld && ex_br_taken;
  assign kill_decode = redirect && !dslot_en;

  // R6: delay-slot mode never squashes the decode instruction
  a_r6_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_en |-> !kill_decode);
endmodule

// File: rtl/hz_mem_arb.sv
module hz_mem_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic shared_mem_en,
  input  logic mem_vld,
  input  logic mem_access,
  output logic fetch_blocked
);
  assign fetch_blocked = shared_mem_en && mem_vld && mem_access;

  // R7: split memories never block fetch
  a_r7_split_free: assert property (@(posedge clk) disable iff (!rst_n)
    !shared_mem_en |-> !fetch_blocked);
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hz_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dslot_en,
  input  logic                 shared_mem_en,
  input  logic                 id_vld,
  input  logic                 ex_vld,
  input  logic                 mem_vld,
  input  logic [HZ_RIDX_W-1:0] ex_rd,
  input  logic                 ex_we,
  input  logic [HZ_RIDX_W-1:0] mem_rd,
  input  logic                 mem_we,
  input  logic [HZ_RIDX_W-1:0] id_rs1,
  input  logic                 id_rs1_use,
  input  logic [HZ_RIDX_W-1:0] id_rs2,
  input  logic                 id_rs2_use,
  input  logic                 ex_br_taken,
  input  logic                 mem_access,
  output logic                 pc_hold,
  output logic                 ifid_hold,
  output logic                 idex_bubble,
  output logic                 if_flush,
  output logic                 id_flush
);
  src_t  srcs  [HZ_NSRC];
  prod_t prods [HZ_NPROD];

  assign srcs[0]  = '{idx: id_rs1, used: id_rs1_use};
  assign srcs[1]  = '{idx: id_rs2, used: id_rs2_use};
  assign prods[0] = '{rd: ex_rd,  we: ex_we,  vld: ex_vld};
  assign prods[1] = '{rd: mem_rd, we: mem_we, vld: mem_vld};

  // Named internal events
  logic raw_stall;
  logic redirect;
  logic kill_decode;
  logic fetch_blocked;
  logic hold_decode;

  hz_raw_detect #(.NSRC(HZ_NSRC), .NPROD(HZ_NPROD)) u_raw (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_vld    (id_vld),
    .src       (srcs),
    .prod      (prods),
    .raw_stall (raw_stall)
  );

  hz_squash u_sq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_vld      (ex_vld),
    .ex_br_taken (ex_br_taken),
    .dslot_en    (dslot_en),
    .redirect    (redirect),
    .kill_decode (kill_decode)
  );

  hz_mem_arb u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .shared_mem_en (shared_mem_en),
    .mem_vld       (mem_vld),
    .mem_access    (mem_access),
    .fetch_blocked (fetch_blocked)
  );

  // A squashed decode instruction no longer needs its operands.
  assign hold_decode = raw_stall && !kill_decode;

  always_comb begin
    ifid_hold   = hold_decode;
    idex_bubble = hold_decode;
    id_flush    = kill_decode;
    pc_hold     = !redirect && (hold_decode || fetch_blocked);
    if_flush    = !hold_decode && (redirect || fetch_blocked);
  end

  // R1: dependence on execute stalls the front end
  a_r1_ex_dep: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && id_rs1_use && id_rs1 != '0 && ex_vld && ex_we && ex_rd == id_rs1
     && !ex_br_taken) |-> (pc_hold && ifid_hold && idex_bubble));

  // R2: dependence on memory stage stalls the front end
  a_r2_mem_dep: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && id_rs2_use && id_rs2 != '0 && mem_vld && mem_we && mem_rd == id_rs2
     && !(ex_vld && ex_br_taken)) |-> (pc_hold && idex_bubble));

  // R5: taken branch without delay slot wins over every stall
  a_r5_squash: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld && ex_br_taken && !dslot_en) |->
      (id_flush && if_flush && !pc_hold && !ifid_hold && !idex_bubble));

  // R7: shared-port conflict freezes the program counter
  a_r7_port_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_mem_en && mem_vld && mem_access && !(ex_vld && ex_br_taken)) |-> pc_hold);

  // R8: hold and bubble pair up; RAW bubble and squash are exclusive
  a_r8_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    (ifid_hold == idex_bubble) && !(idex_bubble && id_flush));

  // R9: empty pipeline leaves every control output low
  a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_vld && !ex_vld && !mem_vld) |->
      !(pc_hold || ifid_hold || idex_bubble || if_flush || id_flush));
endmodule

// File: tb/tb_hazard_interlock.sv
module tb_hazard_interlock;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       dslot_en, shared_mem_en, id_vld, ex_vld, mem_vld;
  logic [4:0] ex_rd, mem_rd, id_rs1, id_rs2;
  logic       ex_we, mem_we, id_rs1_use, id_rs2_use, ex_br_taken, mem_access;
  logic       pc_hold, ifid_hold, idex_bubble, if_flush, id_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hazard_interlock dut (
    .clk(clk), .rst_n(rst_n), .dslot_en(dslot_en), .shared_mem_en(shared_mem_en),
    .id_vld(id_vld), .ex_vld(ex_vld), .mem_vld(mem_vld),
    .ex_rd(ex_rd), .ex_we(ex_we), .mem_rd(mem_rd), .mem_we(mem_we),
    .id_rs1(id_rs1), .id_rs1_use(id_rs1_use), .id_rs2(id_rs2), .id_rs2_use(id_rs2_use),
    .ex_br_taken(ex_br_taken), .mem_access(mem_access),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .if_flush(if_flush), .id_flush(id_flush)
  );

  // Bench model, order {pc_hold, ifid_hold, idex_bubble, if_flush, id_flush}
  function automatic bit producer_blocks(bit pv, bit pw, logic [4:0] pr,
                                         bit u, logic [4:0] r);
    if (!u || r == 5'd0) return 1'b0;
    return pv && pw && (pr == r);
  endfunction

  function automatic logic [4:0] expect_out();
    bit dep, br, kill, held, busy;
    dep = 1'b0;
    if (id_vld) begin
      dep = producer_blocks(ex_vld, ex_we, ex_rd, id_rs1_use, id_rs1)
          | producer_blocks(ex_vld, ex_we, ex_rd, id_rs2_use, id_rs2)
          | producer_blocks(mem_vld, mem_we, mem_rd, id_rs1_use, id_rs1)
          | producer_blocks(mem_vld, mem_we, mem_rd, id_rs2_use, id_rs2);
    end
    br   = ex_vld && ex_br_taken;
    kill = br && !dslot_en;
    held = dep && !kill;
    busy = shared_mem_en && mem_vld && mem_access;
    return {(!br && (held || busy)), held, held, (!held && (br || busy)), kill};
  endfunction

  task automatic clear_inputs();
    {dslot_en, shared_mem_en, id_vld, ex_vld, mem_vld} = '0;
    {ex_rd, mem_rd, id_rs1, id_rs2} = '0;
    {ex_we, mem_we, id_rs1_use, id_rs2_use, ex_br_taken, mem_access} = '0;
  endtask

  task automatic check(string tag, logic [4:0] want);
    logic [4:0] got;
    @(negedge clk);
    #1;
    got = {pc_hold, ifid_hold, idex_bubble, if_flush, id_flush};
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, want);
    end
  endtask

  task automatic check_model(string tag);
    check(tag, expect_out());
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    clear_inputs();
    repeat (3) @(posedge clk);
    // R9: empty pipeline in reset and after
    check("R9 reset", 5'b00000);
    rst_n = 1'b1;
    check("R9 idle", 5'b00000);

    // R1: ADD writes r4 in execute, OR reads r4 in decode
    clear_inputs(); id_vld = 1; ex_vld = 1; ex_we = 1; ex_rd = 4;
    id_rs1 = 4; id_rs1_use = 1;
    check("R1 ex producer", 5'b11100);

    // R2: producer in memory stage on second source
    clear_inputs(); id_vld = 1; mem_vld = 1; mem_we = 1; mem_rd = 9;
    id_rs2 = 9; id_rs2_use = 1;
    check("R2 mem producer", 5'b11100);

    // R3: no write enable, invalid stage, invalid decode
    clear_inputs(); id_vld = 1; ex_vld = 1; ex_we = 0; ex_rd = 4; id_rs1 = 4; id_rs1_use = 1;
    check("R3 no write", 5'b00000);
    ex_we = 1; ex_vld = 0;
    check("R3 stage invalid", 5'b00000);
    ex_vld = 1; id_vld = 0;
    check("R3 decode invalid", 5'b00000);

    // R4: zero register and unused operand
    clear_inputs(); id_vld = 1; ex_vld = 1; ex_we = 1; ex_rd = 0; id_rs1 = 0; id_rs1_use = 1;
    check("R4 zero reg", 5'b00000);
    ex_rd = 7; id_rs1 = 7; id_rs1_use = 0;
    check("R4 unused src", 5'b00000);

    // R5: taken branch, no delay slot, with RAW and memory conflict present
    clear_inputs(); id_vld = 1; ex_vld = 1; ex_we = 1; ex_rd = 3; id_rs2 = 3; id_rs2_use = 1;
    ex_br_taken = 1; shared_mem_en = 1; mem_vld = 1; mem_access = 1;
    check("R5 squash priority", 5'b00011);

    // R6: delay slot, no RAW then with RAW
    clear_inputs(); dslot_en = 1; id_vld = 1; ex_vld = 1; ex_br_taken = 1;
    check("R6 slot kept", 5'b00010);
    mem_vld = 1; mem_we = 1; mem_rd = 12; id_rs1 = 12; id_rs1_use = 1;
    check("R6 slot stalled", 5'b01100);

    // R7: shared port on, off, and with a RAW stall
    clear_inputs(); shared_mem_en = 1; mem_vld = 1; mem_access = 1;
    check("R7 port turn", 5'b10010);
    shared_mem_en = 0;
    check("R7 split memories", 5'b00000);
    shared_mem_en = 1; id_vld = 1; ex_vld = 1; ex_we = 1; ex_rd = 5; id_rs2 = 5; id_rs2_use = 1;
    check("R7 with raw", 5'b11100);

    // Random mix, small register range to provoke matches
    void'($urandom(32'd1207));
    for (int i = 0; i < 3000; i++) begin
      string tag;
      dslot_en = $urandom % 2; shared_mem_en = $urandom % 2;
      id_vld = ($urandom % 4) != 0; ex_vld = ($urandom % 4) != 0; mem_vld = ($urandom % 4) != 0;
      ex_rd = $urandom % 4; mem_rd = $urandom % 4; id_rs1 = $urandom % 4; id_rs2 = $urandom % 4;
      ex_we = $urandom % 2; mem_we = $urandom % 2;
      id_rs1_use = $urandom % 2; id_rs2_use = $urandom % 2;
      ex_br_taken = ($urandom % 4) == 0; mem_access = $urandom % 2;
      if (ex_vld && ex_br_taken) tag = dslot_en ? "R6 random" : "R5 random";
      else if (shared_mem_en && mem_vld && mem_access) tag = "R7 random";
      else tag = "R1 R2 R8 random";
      check_model(tag);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule